// File: doc/BRIEF.md
# Keyed-Control Watchdog Timer

This block is a watchdog driven by a slow-clock tick. One 8-bit control register holds a 5-bit key and a 3-bit timeout selector. With the enable key loaded, a binary prescaler counts slow-clock ticks. If software does not restart it in time, the block raises a one-cycle reset request. The disable key stops the count. Any other key value is treated as corruption: after a fixed delay measured in slow-clock ticks, the block asserts a reset request and sets a sticky flag that records the cause.

All state is held in the system clock domain. The slow clock reaches the block as a one-cycle enable, `slow_en`, and all counting and key synchronisation advance only on cycles where it is high. A software clear strobe or a control write can arrive in any cycle. It is held pending and applied on the next tick. When it arrives in a tick cycle, it takes effect in that same tick.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the control register reads 8'h53 (key 5'b01010, selector 3'b011), the cause flag reads 0 and the reset request is low.
- R2: With key 5'b01010 in bits 7..3, the reset request goes high for exactly one cycle on the 2^(8+sel)-th tick after the count last restarted. Reset release or a restart tick counts as tick zero.
- R3: Selector codes 0 to 7 in bits 2..0 choose timeouts of 256, 512, 1024, 2048, 4096, 8192, 16384 and 32768 ticks respectively.
- R4: With key 5'b10101, no timeout request is raised and the count is held at zero.
- R5: With any key other than the two legal values, the reset request goes high on the third tick after the write that loaded it. The request stays high while that key stays loaded. It falls on the third tick after a legal key is written.
- R6: An illegal-key reset sets the cause flag. A timeout request never sets it.
- R7: The cause flag stays set until a flag write with data 0. A flag write with data 1 has no effect. While an illegal-key request is active, the set overrides a clear.
- R8: A clear strobe restarts the count on the next tick, which becomes tick zero. A strobe in a cycle without a tick is held until a tick arrives.
- R9: Every control write restarts the count in the same way as a clear strobe, even when the value written is unchanged.
- R10: The control register output shows the last value written on the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | One-cycle tick marking each slow-clock period |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control value: key in bits 7..3, selector in bits 2..0 |
| flag_we | input | 1 | Cause-flag write strobe |
| flag_wdata | input | 1 | Cause-flag write data (0 clears it) |
| clr_i | input | 1 | Software clear strobe for the count |
| ctrl_o | output | 8 | Current control register |
| wrf_o | output | 1 | Sticky illegal-key reset flag |
| rst_req_o | output | 1 | Reset request (timeout pulse or illegal-key level) |

## Verification
The bench measures every selector's timeout to the exact cycle. A tap off by one stage would double or halve the period, and an off-by-one in the restart would land one cycle early or late. It times the illegal-key request in ticks for two different bad patterns, with ticks spaced four cycles apart. A design that skipped a synchroniser stage, or counted system cycles instead of ticks, would fire on the wrong tick. A clear strobe is raised between ticks to catch a design that drops the strobe or restarts immediately. The bench also tries to clear the cause flag while a bad key is active, and writes a 1 to it, to catch a clear that wins over the set or a write that sets the flag.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int KEY_W    = 5,
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 8,
  parameter int SYNC_N   = 3,
  parameter logic [KEY_W-1:0] KEY_ON  = 5'b01010,
  parameter logic [KEY_W-1:0] KEY_OFF = 5'b10101,
  parameter logic [SEL_W-1:0] SEL_RST = 3'b011
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slow_en,
  input  logic                     wr_en,
  input  logic [KEY_W+SEL_W-1:0]   wr_data,
  input  logic                     flag_we,
  input  logic                     flag_wdata,
  input  logic                     clr_i,
  output logic [KEY_W+SEL_W-1:0]   ctrl_o,
  output logic                     wrf_o,
  output logic                     rst_req_o
);
  localparam int CTRL_W = KEY_W + SEL_W;
  localparam int N_SEL  = 1 << SEL_W;
  localparam int CNT_W  = BASE_EXP + N_SEL - 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SYNC_N-1:0] sync_q, sync_n;
  logic [N_SEL-1:0]  tap;
  logic              pend_q, to_q, wrf_q;

  wire [KEY_W-1:0] key     = ctrl_q[CTRL_W-1:SEL_W];
  wire [SEL_W-1:0] sel     = ctrl_q[SEL_W-1:0];
  wire             wd_on   = (key == KEY_ON);
  wire             key_bad = !wd_on && (key != KEY_OFF);
  wire             restart = pend_q | clr_i | wr_en;
  wire             expire  = tap[sel];
  wire             flag_clr = flag_we && !flag_wdata;

  for (genvar s = 0; s < N_SEL; s++) begin : g_tap
    assign tap[s] = &cnt_q[BASE_EXP+s-1:0];
  end

  assign sync_n = slow_en ? {sync_q[SYNC_N-2:0], key_bad} : sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= {KEY_ON, SEL_RST};
      pend_q <= 1'b0;
      cnt_q  <= '0;
      to_q   <= 1'b0;
      sync_q <= '0;
      wrf_q  <= 1'b0;
    end else begin
      if (wr_en) ctrl_q <= wr_data;
      pend_q <= slow_en ? 1'b0 : restart;
      if (slow_en) begin
        if (restart || !wd_on || expire) cnt_q <= '0;
        else                             cnt_q <= cnt_q + 1'b1;
      end
      to_q   <= slow_en && wd_on && !restart && expire;
      sync_q <= sync_n;
      wrf_q  <= (wrf_q && !flag_clr) || sync_n[SYNC_N-1];
    end
  end

  assign ctrl_o    = ctrl_q;
  assign wrf_o     = wrf_q;
  assign rst_req_o = sync_q[SYNC_N-1] | to_q;

  p_pulse_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |=> !to_q);
  p_timeout_needs_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> $past(wd_on));
  p_off_holds_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_en && key == KEY_OFF) |=> cnt_q == '0);
  p_bad_req_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q[SYNC_N-1]) |-> $past(slow_en));
  p_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrf_q) |-> sync_q[SYNC_N-1]);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrf_q && !flag_clr) |=> wrf_q);
  p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_en && (wr_en || clr_i)) |=> cnt_q == '0);
endmodule

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, flag_we = 1'b0, flag_wdata = 1'b0, clr_i = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_o;
  logic wrf_o, rst_req_o, slow_en;
  int div_n = 1;
  int div_cnt = 0;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) div_cnt <= (div_cnt + 1 >= div_n) ? 0 : div_cnt + 1;
  assign slow_en = (div_cnt == 0);

  keyed_wdt dut_i (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .wr_en(wr_en), .wr_data(wr_data),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .clr_i(clr_i),
    .ctrl_o(ctrl_o), .wrf_o(wrf_o), .rst_req_o(rst_req_o)
  );

  localparam logic [39:0] VEC [0:8] = '{
    {5'b01010, 3'd0, 32'd256},   {5'b01010, 3'd1, 32'd512},
    {5'b01010, 3'd2, 32'd1024},  {5'b01010, 3'd3, 32'd2048},
    {5'b01010, 3'd4, 32'd4096},  {5'b01010, 3'd5, 32'd8192},
    {5'b01010, 3'd6, 32'd16384}, {5'b01010, 3'd7, 32'd32768},
    {5'b10101, 3'd0, 32'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(posedge clk); #1;
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_flag(input logic v);
    flag_we = 1'b1; flag_wdata = v;
    @(posedge clk); #1;
    flag_we = 1'b0;
    @(negedge clk);
  endtask

  // Counts edges (by_tick=0) or ticks (by_tick=1) until rst_req_o equals lvl; 0 if limit reached.
  task automatic wait_req(input bit by_tick, input logic lvl, input int limit, output int n);
    int cnt = 0;
    n = 0;
    for (int e = 0; e < limit; e++) begin
      logic t;
      t = slow_en;
      @(posedge clk); #1;
      if (t || !by_tick) cnt++;
      if (rst_req_o == lvl) begin
        n = cnt;
        @(negedge clk);
        return;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..: run did not complete, actual hang expected finish");
    summary();
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(ctrl_o == 8'h53, "R1 ctrl reset", ctrl_o, 8'h53);
    chk(wrf_o == 1'b0, "R1 flag reset", wrf_o, 0);
    chk(rst_req_o == 1'b0, "R1 req reset", rst_req_o, 0);
    rst_n = 1'b1;
    wait_req(1'b0, 1'b1, 2100, n);
    chk(n == 2048, "R1 R3 default timeout", n, 2048);
    chk(wrf_o == 1'b0, "R6 timeout leaves flag", wrf_o, 0);

    foreach (VEC[i]) begin
      logic [7:0] cv;
      int exp;
      cv = VEC[i][39:32];
      exp = int'(VEC[i][31:0]);
      write_ctrl({5'b10101, cv[2:0]});
      write_ctrl(cv);
      chk(ctrl_o == cv, "R10 readback", ctrl_o, cv);
      if (exp > 0) begin
        wait_req(1'b0, 1'b1, exp + 10, n);
        chk(n == exp, "R2 R3 timeout length", n, exp);
        @(posedge clk); #1;
        chk(rst_req_o == 1'b0, "R2 one-cycle pulse", rst_req_o, 0);
        @(negedge clk);
      end else begin
        wait_req(1'b0, 1'b1, 700, n);
        chk(n == 0, "R4 disabled no request", n, 0);
      end
    end
    chk(wrf_o == 1'b0, "R6 flag after timeouts", wrf_o, 0);

    write_ctrl({5'b01010, 3'd0});
    wait_req(1'b0, 1'b1, 200, n);
    chk(n == 0, "R9 no early request", n, 0);
    write_ctrl({5'b01010, 3'd0});
    wait_req(1'b0, 1'b1, 300, n);
    chk(n == 256, "R9 rewrite restarts", n, 256);

    div_n = 4;
    write_ctrl({5'b01010, 3'd0});
    repeat (40) @(negedge clk);
    while (slow_en) @(negedge clk);
    clr_i = 1'b1;
    @(posedge clk); #1;
    clr_i = 1'b0;
    @(negedge clk);
    wait_req(1'b1, 1'b1, 1200, n);
    chk(n == 257, "R8 clear waits for tick", n, 257);

    write_ctrl({5'b10101, 3'd7});
    write_ctrl(8'hFF);
    chk(ctrl_o == 8'hFF, "R10 readback bad key", ctrl_o, 8'hFF);
    wait_req(1'b1, 1'b1, 40, n);
    chk(n == 3, "R5 bad key latency", n, 3);
    chk(wrf_o == 1'b1, "R6 flag set by bad key", wrf_o, 1);
    repeat (12) @(negedge clk);
    chk(rst_req_o == 1'b1, "R5 request held", rst_req_o, 1);
    write_flag(1'b0);
    chk(wrf_o == 1'b1, "R7 set beats clear", wrf_o, 1);
    write_ctrl({5'b01010, 3'd7});
    wait_req(1'b1, 1'b0, 40, n);
    chk(n == 3, "R5 release latency", n, 3);
    chk(wrf_o == 1'b1, "R7 flag sticky", wrf_o, 1);
    write_flag(1'b1);
    chk(wrf_o == 1'b1, "R7 write one ignored", wrf_o, 1);
    write_flag(1'b0);
    chk(wrf_o == 1'b0, "R7 write zero clears", wrf_o, 0);

    write_ctrl({5'b00000, 3'd7});
    wait_req(1'b1, 1'b1, 40, n);
    chk(n == 3, "R5 second bad pattern", n, 3);
    chk(wrf_o == 1'b1, "R6 flag set again", wrf_o, 1);
    write_ctrl({5'b10101, 3'd7});
    wait_req(1'b1, 1'b0, 40, n);
    chk(n == 3, "R5 release to disabled", n, 3);

    summary();
    $finish;
  end
endmodule